// File: doc/BRIEF.md
# Base-Plus-Immediate Adder

This block adds a full-width base operand to a short signed immediate. Typical uses are load/store address generation and branch-target calculation. The immediate is treated as a two's-complement value of K bits and sign-extended to N bits. Only the low K bits go through a real adder.

The upper N-K bits of the result need no general adder. Above bit K-1 the sign-extended immediate is all copies of its sign bit. The upper result is therefore the base's upper field as it is, plus one, or minus one. The choice depends only on the immediate's sign and the carry out of the low part. When the sign equals that carry, the upper field passes through unchanged. In that case the increment/decrement logic sees a zero operand and a multiplexer selects the bypass.

The work is split over two register stages. The first stage adds the low part and records the carry and the base's upper field. The second stage applies the upper adjustment and registers the sum. A valid bit travels with each operand. A new operand can be accepted on every cycle, and each result appears exactly two cycles later.

Top module: `imm_offset_adder`

## Requirements
- R1: While reset is held and after it is released, and before any valid input has reached the output, out_valid is 0 and out_sum is 0.
- R2: For an operand accepted with in_valid=1, two rising edges later out_sum equals in_base + sign_extend(in_imm) modulo 2^N, where in_imm bit K-1 is the sign.
- R3: out_valid equals in_valid as sampled two rising edges earlier.
- R4: The low K bits of out_sum equal (in_base[K-1:0] + in_imm) modulo 2^K.
- R5: With a non-negative immediate and no carry out of the low K bits, the upper N-K result bits equal in_base[N-1:K] unchanged.
- R6: With a negative immediate and a carry out of the low K bits, the upper N-K result bits equal in_base[N-1:K] unchanged.
- R7: With a non-negative immediate and a carry out of the low K bits, the upper bits equal in_base[N-1:K]+1, and an all-ones upper field wraps to all zeros.
- R8: With a negative immediate and no carry out of the low K bits, the upper bits equal in_base[N-1:K]-1, and an all-zeros upper field wraps to all ones.
- R9: Operands presented on consecutive cycles each produce their own correct result on consecutive cycles.
- R10: When out_valid is 0, out_sum keeps the value of the last valid result (0 if there has been none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_base | input | N | Full-width base operand |
| in_imm | input | K | Signed immediate, sign in bit K-1 |
| out_valid | output | 1 | out_sum holds a new result |
| out_sum | output | N | Registered sum, two cycles after input |

## Verification
In any single cycle, the second stage can be finishing the upper adjustment of one operand while the first stage computes the carry of the next one. A mix-up between these two would pair an upper field with the wrong carry. The bench provokes this with back-to-back operands that alternate between adjusting and bypassing cases, including ripple wrap at all-ones and all-zeros upper fields. Each output is judged against an independently computed sum of the operand that entered exactly two cycles before. Idle gaps between bursts check that the held sum is not disturbed.

// File: rtl/imm_offset_adder.sv
module imm_offset_adder #(
  parameter int N = 32,
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] in_base,
  input  logic [K-1:0] in_imm,
  output logic         out_valid,
  output logic [N-1:0] out_sum
);
  localparam int HW = N - K;

  logic [K:0]    lo_full;
  logic          imm_neg;
  logic          v1, adj1, dec1;
  logic [K-1:0]  lo1;
  logic [HW-1:0] hi1, hi_opnd, hi_step, hi_adj, hi_res;

  assign lo_full = {1'b0, in_base[K-1:0]} + {1'b0, in_imm};
  assign imm_neg = in_imm[K-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      lo1  <= '0;
      hi1  <= '0;
      adj1 <= 1'b0;
      dec1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        lo1  <= lo_full[K-1:0];
        hi1  <= in_base[N-1:K];
        adj1 <= imm_neg ^ lo_full[K];
        dec1 <= imm_neg;
      end
    end
  end

  assign hi_opnd = adj1 ? hi1 : '0;
  assign hi_step = (adj1 && dec1) ? {HW{1'b1}} : (adj1 ? HW'(1) : '0);
  assign hi_adj  = hi_opnd + hi_step;
  assign hi_res  = adj1 ? hi_adj : hi1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_sum <= {hi_res, lo1};
    end
  end

  // R3
  valid_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1) else $error("valid lost in stage 1");
  // R3
  valid_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid) else $error("valid lost in stage 2");
  // R4
  low_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_sum[K-1:0] == $past(lo1)) else $error("low part mismatch");
  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !adj1) |=> out_sum[N-1:K] == $past(hi1)) else $error("bypass mismatch");
  // R7
  incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && adj1 && !dec1) |=> out_sum[N-1:K] == $past(hi1 + HW'(1))) else $error("increment mismatch");
  // R8
  decr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && adj1 && dec1) |=> out_sum[N-1:K] == $past(hi1 - HW'(1))) else $error("decrement mismatch");
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(out_sum)) else $error("sum changed while idle");
endmodule

// File: tb/imm_offset_adder_test.sv
module imm_offset_adder_test;
  localparam int N = 32;
  localparam int K = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_base = '0;
  logic [K-1:0] in_imm = '0;
  logic         out_valid;
  logic [N-1:0] out_sum;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic         ev1 = 0, ev2 = 0;
  logic [N-1:0] ex1 = '0, ex2 = '0;
  logic [K-1:0] ey1 = '0, ey2 = '0;
  logic [N-1:0] held = '0;

  imm_offset_adder #(.N(N), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
    .in_imm(in_imm), .out_valid(out_valid), .out_sum(out_sum));

  always #4 clk = ~clk;

  function automatic logic [N-1:0] ref_sum(logic [N-1:0] x, logic [K-1:0] y);
    return x + {{(N-K){y[K-1]}}, y};
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [N-1:0] x, logic [K-1:0] y);
    logic [K:0] lo;
    logic [N-1:0] e;
    string cls;
    @(negedge clk);
    chk("R3 valid", {{(N-1){1'b0}}, out_valid}, {{(N-1){1'b0}}, ev2});
    if (ev2) begin
      e  = ref_sum(ex2, ey2);
      lo = {1'b0, ex2[K-1:0]} + {1'b0, ey2};
      chk("R2/R9 sum", out_sum, e);
      chk("R4 low", {{(N-K){1'b0}}, out_sum[K-1:0]}, {{(N-K){1'b0}}, lo[K-1:0]});
      case ({ey2[K-1], lo[K]})
        2'b00: cls = "R5 upper";
        2'b11: cls = "R6 upper";
        2'b01: cls = "R7 upper";
        default: cls = "R8 upper";
      endcase
      chk(cls, {{K{1'b0}}, out_sum[N-1:K]}, {{K{1'b0}}, e[N-1:K]});
      held = e;
    end else begin
      chk("R10 hold", out_sum, held);
    end
    ev2 = ev1; ex2 = ex1; ey2 = ey1;
    ev1 = v;   ex1 = x;   ey1 = y;
    in_valid = v; in_base = x; in_imm = y;
  endtask

  initial begin
    int n = 0;
    while (!done && n < 100000) begin @(posedge clk); n++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", n);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {{(N-1){1'b0}}, out_valid}, '0);
    chk("R1 reset sum", out_sum, '0);
    rst_n = 1'b1;
    step(0, '0, '0);
    step(0, '0, '0);
    // directed corners: R5..R8 with wrap, back-to-back for R9
    step(1, 32'hFFFF_FFFF, 16'h0001);   // R7 wrap to zero
    step(1, 32'h0000_0000, 16'hFFFF);   // R8 wrap to all ones
    step(1, 32'h0001_0000, 16'hFFFF);   // R8
    step(1, 32'h1234_8000, 16'h8000);   // R6
    step(1, 32'hABCD_0010, 16'h0020);   // R5
    step(1, 32'h7FFF_FFFF, 16'h7FFF);   // R7
    step(0, '0, '0);
    step(0, 32'h5555_5555, 16'h1234);   // idle input ignored, R10
    step(1, 32'hFFFF_0000, 16'h8000);   // R8
    step(1, 32'h0000_FFFF, 16'hFFFF);   // R6
    for (int i = 0; i < 2000; i++) begin
      logic [N-1:0] x;
      logic [K-1:0] y;
      x = $urandom;
      y = $urandom;
      case ($urandom % 4)
        0: x[N-1:K] = '1;
        1: x[N-1:K] = '0;
        default: ;
      endcase
      step(($urandom % 5) != 0, x, y);
    end
    step(0, '0, '0);
    step(0, '0, '0);
    step(0, '0, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule